// File: doc/BRIEF.md
# Descriptor-Chain Transmit DMA Engine

This block follows a singly linked chain of transmit buffer descriptors held in local memory. Each descriptor takes four consecutive 32-bit words. Software loads the address of the first descriptor into the head register. The engine then reads each descriptor's words one at a time over a synchronous memory port. It presents the buffer address and length to a downstream consumer on a valid/ready request channel. Once that request is taken, it writes the mode word back with the ownership flag cleared, which returns the descriptor to software, and moves on to the next pointer.

When it writes back a descriptor whose next pointer is null, the engine marks end-of-queue in that descriptor and clears its head register. Software sees the stall as a head register that reads zero, and restarts by writing a fresh head address. A channel enable gates the start of each descriptor. A completion register holds the address software last acknowledged. A self-clearing soft reset returns every piece of state to its power-on value.

Top module: `txdesc_dma`

## Requirements
- R1: A descriptor at byte address A is read from A+0 (next pointer), A+4 (buffer address), A+8 (buffer length) and A+12 (mode word), in that order.
- R2: The request channel carries the fetched buffer address and the low LENW bits of the length word. While buf_valid is high and buf_ready is low, address and length stay unchanged.
- R3: A descriptor is processed only if bit 29 (ownership) of its mode word is 1. If that bit is 0, the engine issues no request and writes nothing, the head register goes to zero and the engine stops.
- R4: After the request is accepted, and not before, the mode word is written back to A+12 with bit 29 cleared. Bit 31 (start of packet), bit 30 (end of packet) and bits 10:0 (packet length) keep their fetched values.
- R5: If the next pointer is nonzero, the written-back mode word leaves bit 28 as fetched. The head register then takes the next pointer and processing continues from it.
- R6: If the next pointer is zero, the written-back mode word has bit 28 (end of queue) set, the head register reads zero and the engine goes idle.
- R7: A write to register select 0 (head) while the engine is idle loads the head register, and a nonzero head with the channel enabled starts processing. A head write while a descriptor is in progress is ignored.
- R8: Register select 1 (completion) holds the last value written to it and shows it on cpl_ptr.
- R9: Register select 2, bit 0, is the channel enable. With it at 0, no new descriptor is started. Clearing it mid-descriptor lets that descriptor finish, after which the engine stops with the head register holding the next pointer. Setting it again resumes from there.
- R10: Writing 1 to bit 0 of register select 3 raises srst_pend for exactly one cycle. In the following cycle the head, completion and enable registers read zero and no request or memory access is active.
- R11: After rst_n the head, completion, enable and soft-reset registers read zero and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 head, 1 completion, 2 enable, 3 soft reset |
| cfg_wdata | input | AW | Register write data |
| head_ptr | output | AW | Head register (descriptor in progress, zero when stalled) |
| cpl_ptr | output | AW | Completion register |
| chan_en | output | 1 | Channel enable register |
| srst_pend | output | 1 | Soft reset pending (self-clearing) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |
| buf_valid | output | 1 | Buffer request valid |
| buf_ready | input | 1 | Buffer request accepted |
| buf_addr | output | AW | Buffer address |
| buf_len | output | LENW | Buffer length |

## Verification
The hardest cases to reach are those where a register write arrives while a descriptor is in flight: a head write that must be dropped, and an enable cleared between fetch and write-back. The bench holds buf_ready low so that the engine parks in its request state. It then issues the write, watches the held request, and only afterwards releases the handshake. For the dropped head write, the bench points the rejected address at an owned decoy descriptor. Any fetch of the decoy would give an unexpected request on the scoreboard and a visible read of its address range.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
   localparam logic [1:0] SEL_HEAD = 2'd0;
   localparam logic [1:0] SEL_CPL  = 2'd1;
   localparam logic [1:0] SEL_EN   = 2'd2;
   localparam logic [1:0] SEL_SRST = 2'd3;

   localparam int MODE_SOP = 31;
   localparam int MODE_EOP = 30;
   localparam int MODE_OWN = 29;
   localparam int MODE_EOQ = 28;
   localparam int MODE_LENBITS = 11;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_RD_NXT,
      WS_RD_BUF,
      WS_RD_LEN,
      WS_RD_MODE,
      WS_CHK,
      WS_REQ,
      WS_WB
   } walk_state_t;
endpackage

// File: rtl/txd_regfile.sv
module txd_regfile
   import txdma_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [AW-1:0] cfg_wdata,
   output logic [AW-1:0] cpl_q,
   output logic          en_q,
   output logic          srst_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpl_q  <= '0;
         en_q   <= 1'b0;
         srst_q <= 1'b0;
      end else if (srst_q) begin
         cpl_q  <= '0;
         en_q   <= 1'b0;
         srst_q <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_sel)
            SEL_CPL:  cpl_q  <= cfg_wdata;
            SEL_EN:   en_q   <= cfg_wdata[0];
            SEL_SRST: srst_q <= cfg_wdata[0];
            default:  ;
         endcase
      end
   end

   // R10: pending flag lasts one cycle and clears the registers behind it
   assert_selfclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |=> !srst_q && cpl_q == '0 && !en_q);

   // R8: completion value only moves on a write or a soft reset
   assert_cpl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we && !srst_q |=> $stable(cpl_q));
endmodule

// File: rtl/txd_walker.sv
module txd_walker
   import txdma_pkg::*;
#(
   parameter int AW            = 32,
   parameter int LENW          = 16,
   parameter bit LEN_FROM_MODE = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            srst,
   input  logic            en,
   input  logic            head_we,
   input  logic [AW-1:0]   head_wdata,
   output logic [AW-1:0]   head_q,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [31:0]     mem_wdata,
   input  logic [31:0]     mem_rdata,
   output logic            buf_valid,
   input  logic            buf_ready,
   output logic [AW-1:0]   buf_addr,
   output logic [LENW-1:0] buf_len
);
   localparam logic [AW-1:0] OFS_BUF  = AW'(4);
   localparam logic [AW-1:0] OFS_LEN  = AW'(8);
   localparam logic [AW-1:0] OFS_MODE = AW'(12);

   walk_state_t     state_q;
   logic [AW-1:0]   nxt_q;
   logic [AW-1:0]   bufp_q;
   logic [LENW-1:0] len_q;
   logic [31:0]     mode_q;
   logic [AW-1:0]   ofs;
   logic            last_desc;

   assign last_desc = (nxt_q == '0);

   always_comb begin
      case (state_q)
         WS_RD_BUF:          ofs = OFS_BUF;
         WS_RD_LEN:          ofs = OFS_LEN;
         WS_RD_MODE, WS_WB:  ofs = OFS_MODE;
         default:            ofs = '0;
      endcase
   end

   assign mem_req   = (state_q == WS_RD_NXT) || (state_q == WS_RD_BUF) ||
                      (state_q == WS_RD_LEN) || (state_q == WS_RD_MODE) ||
                      (state_q == WS_WB);
   assign mem_we    = (state_q == WS_WB);
   assign mem_addr  = head_q + ofs;
   assign buf_valid = (state_q == WS_REQ);
   assign buf_addr  = bufp_q;

   always_comb begin
      mem_wdata           = mode_q;
      mem_wdata[MODE_OWN] = 1'b0;
      if (last_desc) mem_wdata[MODE_EOQ] = 1'b1;
   end

   generate
      if (LEN_FROM_MODE) begin : g_len_mode
         assign buf_len = LENW'(mode_q[MODE_LENBITS-1:0]);
      end else begin : g_len_word
         assign buf_len = len_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
         head_q  <= '0;
         nxt_q   <= '0;
         bufp_q  <= '0;
         len_q   <= '0;
         mode_q  <= '0;
      end else if (srst) begin
         state_q <= WS_IDLE;
         head_q  <= '0;
         nxt_q   <= '0;
         bufp_q  <= '0;
         len_q   <= '0;
         mode_q  <= '0;
      end else begin
         case (state_q)
            WS_IDLE: begin
               if (head_we)                  head_q  <= head_wdata;
               else if (en && head_q != '0)  state_q <= WS_RD_NXT;
            end
            WS_RD_NXT:  state_q <= WS_RD_BUF;
            WS_RD_BUF: begin
               nxt_q   <= mem_rdata[AW-1:0];
               state_q <= WS_RD_LEN;
            end
            WS_RD_LEN: begin
               bufp_q  <= mem_rdata[AW-1:0];
               state_q <= WS_RD_MODE;
            end
            WS_RD_MODE: begin
               len_q   <= mem_rdata[LENW-1:0];
               state_q <= WS_CHK;
            end
            WS_CHK: begin
               mode_q <= mem_rdata;
               if (mem_rdata[MODE_OWN]) begin
                  state_q <= WS_REQ;
               end else begin
                  head_q  <= '0;
                  state_q <= WS_IDLE;
               end
            end
            WS_REQ: if (buf_ready) state_q <= WS_WB;
            WS_WB: begin
               if (last_desc) begin
                  head_q  <= '0;
                  state_q <= WS_IDLE;
               end else begin
                  head_q  <= nxt_q;
                  state_q <= en ? WS_RD_NXT : WS_IDLE;
               end
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   // R2: request fields hold while the consumer stalls
   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || srst)
      buf_valid && !buf_ready |=> buf_valid && $stable(buf_addr) && $stable(buf_len));

   // R4: write-back follows an accepted request and hands ownership back
   assert_wb_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n || srst)
      mem_we |-> $past(buf_valid && buf_ready) && !mem_wdata[MODE_OWN]);

   // R6: an end-of-queue write-back leaves the head register at zero
   assert_eoq_head_R6: assert property (@(posedge clk) disable iff (!rst_n || srst)
      mem_we && mem_wdata[MODE_EOQ] && nxt_q == '0 |=> head_q == '0);

   // R3: a request is raised only for an owned descriptor
   assert_owned_only_R3: assert property (@(posedge clk) disable iff (!rst_n || srst)
      $rose(buf_valid) |-> mode_q[MODE_OWN]);

   // R1: the request channel and the memory port are never active together
   assert_one_side_R1: assert property (@(posedge clk) disable iff (!rst_n || srst)
      buf_valid |-> !mem_req);
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
   import txdma_pkg::*;
#(
   parameter int AW            = 32,
   parameter int LENW          = 16,
   parameter bit LEN_FROM_MODE = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [1:0]      cfg_sel,
   input  logic [AW-1:0]   cfg_wdata,
   output logic [AW-1:0]   head_ptr,
   output logic [AW-1:0]   cpl_ptr,
   output logic            chan_en,
   output logic            srst_pend,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [31:0]     mem_wdata,
   input  logic [31:0]     mem_rdata,
   output logic            buf_valid,
   input  logic            buf_ready,
   output logic [AW-1:0]   buf_addr,
   output logic [LENW-1:0] buf_len
);
   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("txdesc_dma: AW must lie in 8..32");
      end
      if (LENW < MODE_LENBITS || LENW > 32) begin : g_bad_lenw
         $error("txdesc_dma: LENW must lie in 11..32");
      end
   endgenerate

   logic head_we;
   assign head_we = cfg_we && (cfg_sel == SEL_HEAD) && !srst_pend;

   txd_regfile #(.AW(AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .cpl_q     (cpl_ptr),
      .en_q      (chan_en),
      .srst_q    (srst_pend)
   );

   txd_walker #(.AW(AW), .LENW(LENW), .LEN_FROM_MODE(LEN_FROM_MODE)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .srst       (srst_pend),
      .en         (chan_en),
      .head_we    (head_we),
      .head_wdata (cfg_wdata),
      .head_q     (head_ptr),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .buf_valid  (buf_valid),
      .buf_ready  (buf_ready),
      .buf_addr   (buf_addr),
      .buf_len    (buf_len)
   );

   // R10: soft reset leaves the engine quiet with a null head
   assert_srst_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      srst_pend |=> head_ptr == '0 && !buf_valid && !mem_req);

   // R9: with the channel off, an idle engine does not touch memory
   assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n || srst_pend)
      !chan_en && !mem_req && !buf_valid |=> !mem_req || mem_we);
endmodule

// File: tb/txdesc_dma_tb.sv
module txdesc_dma_tb;
   localparam int CLK_P = 10;
   localparam int AW    = 32;
   localparam int LENW  = 16;
   localparam int WD    = 20000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [1:0]      cfg_sel = 2'd0;
   logic [AW-1:0]   cfg_wdata = '0;
   logic [AW-1:0]   head_ptr, cpl_ptr, mem_addr, buf_addr;
   logic            chan_en, srst_pend, mem_req, mem_we, buf_valid;
   logic            buf_ready = 1'b0;
   logic [31:0]     mem_wdata;
   logic [31:0]     mem_rdata = '0;
   logic [LENW-1:0] buf_len;

   logic [31:0] mem [64];
   logic        hold_ready = 1'b0;
   logic        bad_fetch = 1'b0;
   int          wr_cnt = 0;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;
   logic [63:0] exp_q[$];

   always #(CLK_P/2) clk = ~clk;

   txdesc_dma #(.AW(AW), .LENW(LENW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .head_ptr(head_ptr), .cpl_ptr(cpl_ptr),
      .chan_en(chan_en), .srst_pend(srst_pend), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .buf_valid(buf_valid), .buf_ready(buf_ready),
      .buf_addr(buf_addr), .buf_len(buf_len)
   );

   // synchronous memory model
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            mem[mem_addr[7:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rdata <= mem[mem_addr[7:2]];
            if (mem_addr >= 32'hA0 && mem_addr < 32'hB0) bad_fetch <= 1'b1;
         end
      end
   end

   always @(negedge clk) buf_ready <= !hold_ready;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: compare every accepted request with the queue head
   always begin
      @(negedge clk);
      #(CLK_P/4);
      if (rst_n && buf_valid && buf_ready) begin
         if (exp_q.size() == 0) begin
            chk("R3 unexpected buffer request", {buf_addr, 16'h0, buf_len}, 64'h0);
         end else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            chk("R2 buffer request", {buf_addr, 16'h0, buf_len}, e);
         end
      end
   end

   task automatic expect_req(input logic [31:0] a, input logic [15:0] l);
      exp_q.push_back({a, 16'h0, l});
   endtask

   task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic put_desc(input logic [31:0] base, input logic [31:0] nxt,
                           input logic [31:0] bp, input logic [31:0] ln,
                           input logic [31:0] md);
      mem[base[7:2]]     = nxt;
      mem[base[7:2] + 1] = bp;
      mem[base[7:2] + 2] = ln;
      mem[base[7:2] + 3] = md;
   endtask

   task automatic idle_wait(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_valid();
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (buf_valid) return;
      end
      chk("R7 request never raised", 64'h0, 64'h1);
   endtask

   function automatic logic [31:0] md_own(input logic [10:0] l);
      return 32'hE000_0000 | {21'h0, l};
   endfunction

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int wc;
      for (int i = 0; i < 64; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 head", 64'(head_ptr), 64'h0);
      chk("R11 cpl", 64'(cpl_ptr), 64'h0);
      chk("R11 en", 64'(chan_en), 64'h0);
      chk("R11 srst", 64'(srst_pend), 64'h0);
      chk("R11 no request", 64'({buf_valid, mem_req}), 64'h0);

      // R8 completion register
      cfg_write(2'd1, 32'h1234_5670);
      chk("R8 cpl first", 64'(cpl_ptr), 64'h1234_5670);
      cfg_write(2'd1, 32'h0000_00C0);
      chk("R8 cpl second", 64'(cpl_ptr), 64'h0000_00C0);

      // R1 R5 R6: three-descriptor chain
      put_desc(32'h40, 32'h80, 32'h1000, 32'd60,   md_own(11'd60));
      put_desc(32'h80, 32'hC0, 32'h2000, 32'd1514, md_own(11'd1514));
      put_desc(32'hC0, 32'h00, 32'h3000, 32'd100,  md_own(11'd100));
      expect_req(32'h1000, 16'd60);
      expect_req(32'h2000, 16'd1514);
      expect_req(32'h3000, 16'd100);
      cfg_write(2'd2, 32'h1);
      cfg_write(2'd0, 32'h40);
      idle_wait(80);
      chk("R6 head zero after chain", 64'(head_ptr), 64'h0);
      chk("R4 R5 D0 mode", 64'(mem[16 + 3]), 64'hC000_003C);
      chk("R4 R5 D1 mode", 64'(mem[32 + 3]), 64'hC000_05EA);
      chk("R6 D2 mode eoq", 64'(mem[48 + 3]), 64'hD000_0064);
      chk("R1 all requests seen", 64'(exp_q.size()), 64'h0);

      // R7 restart after the stall
      put_desc(32'h50, 32'h0, 32'h4000, 32'd64, md_own(11'd64));
      expect_req(32'h4000, 16'd64);
      cfg_write(2'd0, 32'h50);
      idle_wait(30);
      chk("R7 restart eoq", 64'(mem[20 + 3]), 64'hD000_0040);
      chk("R7 restart head", 64'(head_ptr), 64'h0);

      // R3 non-owned descriptor
      put_desc(32'h60, 32'h0, 32'h5000, 32'd80, 32'hC000_0050);
      wc = wr_cnt;
      cfg_write(2'd0, 32'h60);
      idle_wait(30);
      chk("R3 head cleared", 64'(head_ptr), 64'h0);
      chk("R3 mode untouched", 64'(mem[24 + 3]), 64'hC000_0050);
      chk("R3 no write", 64'(wr_cnt), 64'(wc));

      // R7 busy head write ignored, R2 stall hold
      put_desc(32'h70, 32'h90, 32'h6000, 32'd200, md_own(11'd200));
      put_desc(32'h90, 32'h00, 32'h7000, 32'd300, md_own(11'd300));
      put_desc(32'hA0, 32'h00, 32'hDEAD, 32'd99,  md_own(11'd99));
      expect_req(32'h6000, 16'd200);
      expect_req(32'h7000, 16'd300);
      hold_ready = 1'b1;
      cfg_write(2'd0, 32'h70);
      wait_valid();
      cfg_write(2'd0, 32'hA0);
      chk("R7 busy write ignored", 64'(head_ptr), 64'h70);
      idle_wait(3);
      chk("R2 held addr", 64'({buf_valid, buf_addr}), {31'h0, 1'b1, 32'h6000});
      chk("R2 held len", 64'(buf_len), 64'd200);
      hold_ready = 1'b0;
      idle_wait(40);
      chk("R7 decoy never fetched", 64'(bad_fetch), 64'h0);
      chk("R7 decoy mode untouched", 64'(mem[40 + 3]), 64'(md_own(11'd99)));
      chk("R6 D6 eoq", 64'(mem[36 + 3]), 64'hD000_012C);

      // R9 enable cleared mid-descriptor
      put_desc(32'hB0, 32'hD0, 32'h8000, 32'd70, md_own(11'd70));
      put_desc(32'hD0, 32'h00, 32'h9000, 32'd90, md_own(11'd90));
      expect_req(32'h8000, 16'd70);
      hold_ready = 1'b1;
      cfg_write(2'd0, 32'hB0);
      wait_valid();
      cfg_write(2'd2, 32'h0);
      hold_ready = 1'b0;
      idle_wait(40);
      chk("R9 stop at next", 64'(head_ptr), 64'hD0);
      chk("R9 D8 returned", 64'(mem[44 + 3]), 64'hC000_0046);
      chk("R9 D9 still owned", 64'(mem[52 + 3]), 64'(md_own(11'd90)));
      expect_req(32'h9000, 16'd90);
      cfg_write(2'd2, 32'h1);
      idle_wait(30);
      chk("R9 resumed eoq", 64'(mem[52 + 3]), 64'hD000_005A);
      chk("R9 resumed head", 64'(head_ptr), 64'h0);

      // R10 soft reset
      cfg_write(2'd2, 32'h0);
      cfg_write(2'd0, 32'h40);
      chk("R7 idle head load", 64'(head_ptr), 64'h40);
      cfg_write(2'd1, 32'h5);
      cfg_write(2'd3, 32'h1);
      chk("R10 pending", 64'(srst_pend), 64'h1);
      @(negedge clk);
      chk("R10 self-clear", 64'(srst_pend), 64'h0);
      chk("R10 head", 64'(head_ptr), 64'h0);
      chk("R10 cpl", 64'(cpl_ptr), 64'h0);
      chk("R10 en", 64'(chan_en), 64'h0);
      chk("R10 quiet", 64'({buf_valid, mem_req}), 64'h0);
      chk("R2 scoreboard drained", 64'(exp_q.size()), 64'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule